// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data between a 12-bit narrow port A and a 24-bit wide port B. Port B is made of two 12-bit halves, called the low half and the high half. In the A-to-B direction, two narrow words that arrive one after the other are gathered and presented together as one aligned wide word. The low-half path goes through two cascaded registers. The high-half path goes through a single register. Separate, active-low load strobes for each register let the first word travel one stage further than the second.

In the B-to-A direction, each B half has its own capture register. A select control picks which captured half drives port A.

Every control input is first captured in a register on the clock, and only then takes effect. This covers the output enables, the select and all load strobes, so a direction change always lines up with a clock edge. The bidirectional pins are modelled as separate input, output and output-enable signals. Reset is synchronous and active high. It clears every data register, sets every captured control to inactive, and turns both ports' drivers off.

Top module: `nw_bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising clock edge, all data registers clear to zero and all captured controls become inactive (load strobes high, output enables high, select 0). Afterwards `a_oe` and `b_oe` are 0 and `a_out`, `b1_out` and `b2_out` read 0.
- R2: A value applied to any control input takes effect only after the next rising edge captures it. A data register loads at the edge that follows the edge which captured its low strobe, and it takes the data present at that later edge.
- R3: The low-half A path has two stages. Stage one loads `a_in` when its captured strobe `a1s1_ld_n` is low. Stage two loads stage one's previous content when its captured strobe `a1s2_ld_n` is low. `b1_out` shows stage two.
- R4: The high-half A path has one register. It loads `a_in` when its captured strobe `a2_ld_n` is low, and `b2_out` shows it.
- R5: The strobe order in R5 merges two consecutive A words W1 and W2 into one wide word, with W1 on `b1_out` and W2 on `b2_out`. First, strobe stage one while W1 is presented. Then, on the next load edge, strobe stage two and the high register together while W2 is presented.
- R6: A register whose captured strobe is high keeps its content, whatever the data inputs do.
- R7: The B side has two capture registers, one per half. They load `b1_in` and `b2_in` when their own captured strobes `b1_ld_n` and `b2_ld_n` are low.
- R8: With `sel` captured as 0, `a_out` shows the low-half capture register. With `sel` captured as 1, `a_out` shows the high-half capture register.
- R9: The output enables are active low. `a_oe` = 1 exactly when the captured `oe_a_n` is 0, and `b_oe` = 1 exactly when the captured `oe_b_n` is 0. Turning a port off leaves its register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Narrow port input data |
| a_out | output | 12 | Narrow port output data (selected B capture register) |
| a_oe | output | 1 | Narrow port driver enable, active high |
| b1_in | input | 12 | Wide port low-half input data |
| b2_in | input | 12 | Wide port high-half input data |
| b1_out | output | 12 | Wide port low-half output (stage two of low A path) |
| b2_out | output | 12 | Wide port high-half output (high A register) |
| b_oe | output | 1 | Wide port driver enable, active high |
| oe_a_n | input | 1 | Narrow port output enable request, active low |
| oe_b_n | input | 1 | Wide port output enable request, active low |
| sel | input | 1 | Readback select: 0 low half, 1 high half |
| a1s1_ld_n | input | 1 | Load strobe, low A path stage one, active low |
| a1s2_ld_n | input | 1 | Load strobe, low A path stage two, active low |
| a2_ld_n | input | 1 | Load strobe, high A register, active low |
| b1_ld_n | input | 1 | Load strobe, low B capture register, active low |
| b2_ld_n | input | 1 | Load strobe, high B capture register, active low |

## Verification
The bench streams many computed word pairs through the merge sequence. A design that swapped the stages, or that loaded stage two from `a_in`, would put the second word on both halves or leave the first word out. It checks each control's effect just before and just after the capturing edge, which catches a design that lets a strobe, select or enable act combinationally and so acts one cycle early. It sweeps every combination of select and both output enables, to catch an inverted enable or an inverted select. It holds all strobes high while changing the data inputs, to catch a register that loads when it should hold.

// File: rtl/bxchg_pkg.sv
package bxchg_pkg;

    // Captured control word; every field is active low except sel.
    typedef struct packed {
        logic oe_a_n;
        logic oe_b_n;
        logic sel;
        logic a1s1_n;
        logic a1s2_n;
        logic a2_n;
        logic b1_n;
        logic b2_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{oe_a_n: 1'b1, oe_b_n: 1'b1, sel: 1'b0,
                                    a1s1_n: 1'b1, a1s2_n: 1'b1, a2_n: 1'b1,
                                    b1_n: 1'b1, b2_n: 1'b1};

    function automatic logic drv_on(input logic en_n);
        return ~en_n;
    endfunction

endpackage

// File: rtl/bxchg_ctrl_reg.sv
module bxchg_ctrl_reg
    import bxchg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl_in,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_IDLE;
        else     ctrl_q <= ctrl_in;
    end

    // R2
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ctrl_q == $past(ctrl_in));

endmodule

// File: rtl/bxchg_a2b_path.sv
module bxchg_a2b_path #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    input  logic          s1_ld_n,
    input  logic          s2_ld_n,
    input  logic          hi_ld_n,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] hi_q
);

    logic [DW-1:0] stage1_q;
    logic [DW-1:0] stage2_q;
    logic [DW-1:0] high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            high_q   <= '0;
        end else begin
            if (!s1_ld_n) stage1_q <= a_in;
            if (!s2_ld_n) stage2_q <= stage1_q;
            if (!hi_ld_n) high_q   <= a_in;
        end
    end

    assign lo_q = stage2_q;
    assign hi_q = high_q;

    // R3
    stage2_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !s2_ld_n |=> stage2_q == $past(stage1_q));

    // R4
    high_load_chk: assert property (@(posedge clk) disable iff (rst)
        !hi_ld_n |=> high_q == $past(a_in));

    // R6
    stage1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s1_ld_n |=> $stable(stage1_q));

endmodule

// File: rtl/bxchg_b2a_path.sv
module bxchg_b2a_path #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] b1_in,
    input  logic [DW-1:0] b2_in,
    input  logic          b1_ld_n,
    input  logic          b2_ld_n,
    input  logic          sel,
    output logic [DW-1:0] a_q
);

    logic [DW-1:0] cap_lo_q;
    logic [DW-1:0] cap_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (!b1_ld_n) cap_lo_q <= b1_in;
            if (!b2_ld_n) cap_hi_q <= b2_in;
        end
    end

    assign a_q = sel ? cap_hi_q : cap_lo_q;

    // R7
    cap_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        !b1_ld_n |=> cap_lo_q == $past(b1_in));

    // R6
    cap_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        b2_ld_n |=> $stable(cap_hi_q));

endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
    import bxchg_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic          a_oe,
    input  logic [DW-1:0] b1_in,
    input  logic [DW-1:0] b2_in,
    output logic [DW-1:0] b1_out,
    output logic [DW-1:0] b2_out,
    output logic          b_oe,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    input  logic          sel,
    input  logic          a1s1_ld_n,
    input  logic          a1s2_ld_n,
    input  logic          a2_ld_n,
    input  logic          b1_ld_n,
    input  logic          b2_ld_n
);

    ctrl_t ctrl_in;
    ctrl_t ctrl_q;

    assign ctrl_in = '{oe_a_n: oe_a_n, oe_b_n: oe_b_n, sel: sel,
                       a1s1_n: a1s1_ld_n, a1s2_n: a1s2_ld_n, a2_n: a2_ld_n,
                       b1_n: b1_ld_n, b2_n: b2_ld_n};

    bxchg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_in),
        .ctrl_q  (ctrl_q)
    );

    bxchg_a2b_path #(.DW(DW)) u_a2b (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .s1_ld_n (ctrl_q.a1s1_n),
        .s2_ld_n (ctrl_q.a1s2_n),
        .hi_ld_n (ctrl_q.a2_n),
        .lo_q    (b1_out),
        .hi_q    (b2_out)
    );

    bxchg_b2a_path #(.DW(DW)) u_b2a (
        .clk     (clk),
        .rst     (rst),
        .b1_in   (b1_in),
        .b2_in   (b2_in),
        .b1_ld_n (ctrl_q.b1_n),
        .b2_ld_n (ctrl_q.b2_n),
        .sel     (ctrl_q.sel),
        .a_q     (a_out)
    );

    assign a_oe = drv_on(ctrl_q.oe_a_n);
    assign b_oe = drv_on(ctrl_q.oe_b_n);

    // R9
    b_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> b_oe == !$past(oe_b_n));

    // R9
    a_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> a_oe == !$past(oe_a_n));

endmodule

// File: tb/nw_bus_exchanger_tb.sv
module nw_bus_exchanger_tb_top;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [DW-1:0] a_out, b1_out, b2_out;
    logic          a_oe, b_oe;
    logic          oe_a_n = 1'b1, oe_b_n = 1'b1, sel = 1'b0;
    logic          a1s1_ld_n = 1'b1, a1s2_ld_n = 1'b1, a2_ld_n = 1'b1;
    logic          b1_ld_n = 1'b1, b2_ld_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    nw_bus_exchanger #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b2_in(b2_in), .b1_out(b1_out), .b2_out(b2_out),
        .b_oe(b_oe), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .sel(sel),
        .a1s1_ld_n(a1s1_ld_n), .a1s2_ld_n(a1s2_ld_n), .a2_ld_n(a2_ld_n),
        .b1_ld_n(b1_ld_n), .b2_ld_n(b2_ld_n)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobes_idle();
        a1s1_ld_n = 1'b1; a1s2_ld_n = 1'b1; a2_ld_n = 1'b1;
        b1_ld_n = 1'b1; b2_ld_n = 1'b1;
    endtask

    function automatic logic [DW-1:0] wgen(input int k);
        return DW'((k * 1571 + 293) % 4096);
    endfunction

    task automatic merge_pair(input logic [DW-1:0] w1, input logic [DW-1:0] w2);
        strobes_idle(); a1s1_ld_n = 1'b0;
        tick();
        a_in = w1; strobes_idle(); a1s2_ld_n = 1'b0; a2_ld_n = 1'b0;
        tick();
        a_in = w2; strobes_idle();
        tick();
    endtask

    logic [DW-1:0] v1, v2, w1, w2;

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = 12'hfff; b1_in = 12'hfff; b2_in = 12'hfff;
        oe_a_n = 1'b0; oe_b_n = 1'b0; a1s1_ld_n = 1'b0; a2_ld_n = 1'b0;
        tick(); tick(); tick();
        // R1 reset state, with active requests applied during reset
        chk("R1 a_oe", {11'b0, a_oe}, 12'h000);
        chk("R1 b_oe", {11'b0, b_oe}, 12'h000);
        chk("R1 b1_out", b1_out, 12'h000);
        chk("R1 b2_out", b2_out, 12'h000);
        chk("R1 a_out", a_out, 12'h000);
        oe_a_n = 1'b1; oe_b_n = 1'b1; strobes_idle();
        rst = 1'b0;
        tick();

        // R2 enable takes effect exactly one edge later
        oe_b_n = 1'b0;
        #1;
        chk("R2 b_oe before edge", {11'b0, b_oe}, 12'h000);
        tick();
        chk("R2 b_oe after edge", {11'b0, b_oe}, 12'h001);

        // R5 merge sweep over many computed pairs (R3, R4 implied)
        for (int k = 0; k < 40; k++) begin
            w1 = wgen(2 * k);
            w2 = wgen(2 * k + 1);
            merge_pair(w1, w2);
            chk("R5 R3 low half", b1_out, w1);
            chk("R5 R4 high half", b2_out, w2);
        end

        // R2 strobe early-action: data changes at capture edge must not load
        strobes_idle(); a_in = 12'h5a5; a2_ld_n = 1'b0;
        tick();
        chk("R2 no early load b2", b2_out, w2);
        a_in = 12'h3c3; strobes_idle();
        tick();
        chk("R4 high reg load", b2_out, 12'h3c3);

        // R3 stage two alone moves stage one content (last w2 value in stage one? no: stage1 holds last w1)
        strobes_idle(); a1s2_ld_n = 1'b0;
        tick();
        strobes_idle();
        tick();
        chk("R3 stage two reloads from stage one", b1_out, w1);

        // R6 hold: strobes high, data wiggles
        for (int k = 0; k < 8; k++) begin
            a_in = wgen(100 + k); b1_in = wgen(200 + k); b2_in = wgen(300 + k);
            tick();
            chk("R6 hold b1_out", b1_out, w1);
            chk("R6 hold b2_out", b2_out, 12'h3c3);
            chk("R6 hold a_out", a_out, 12'h000);
        end

        // R7 B-side capture and R8 select sweep
        for (int k = 0; k < 16; k++) begin
            v1 = wgen(500 + k); v2 = wgen(700 + k);
            strobes_idle(); b1_ld_n = 1'b0; b2_ld_n = 1'b0;
            tick();
            strobes_idle(); b1_in = v1; b2_in = v2;
            sel = 1'b0;
            tick();
            chk("R7 R8 sel0 low capture", a_out, v1);
            sel = 1'b1;
            #1;
            chk("R2 sel before edge", a_out, v1);
            tick();
            chk("R7 R8 sel1 high capture", a_out, v2);
        end

        // R7 load only one half
        strobes_idle(); b1_ld_n = 1'b0;
        tick();
        strobes_idle(); b1_in = 12'h111; b2_in = 12'h222;
        tick();
        sel = 1'b0; tick();
        chk("R7 low only loaded", a_out, 12'h111);
        sel = 1'b1; tick();
        chk("R7 high kept", a_out, v2);

        // R9 sweep of select and both enables
        for (int m = 0; m < 8; m++) begin
            sel = m[0]; oe_a_n = m[1]; oe_b_n = m[2];
            tick();
            chk("R9 a_oe", {11'b0, a_oe}, {11'b0, ~m[1]});
            chk("R9 b_oe", {11'b0, b_oe}, {11'b0, ~m[2]});
            chk("R9 R8 a_out kept", a_out, m[0] ? v2 : 12'h111);
            chk("R9 b1 kept", b1_out, w1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule